// File: doc/BRIEF.md
# Staged cascade serial-to-parallel converter

This block gathers a serial bit stream into 64-bit parallel words. The bits do not travel down one long shift register. They pass through a chain of stages whose widths double (2, 4, 8, 16, 32, 64 bits). A stage takes in a new chunk only half as often as the stage before it. The front stage takes every accepted bit. Each later stage takes the whole content of its predecessor once that predecessor has collected a complete chunk. A separate word register follows the widest stage and presents the finished word.

One clock drives every stage. The different update rates come from clock enables, which are decoded from a shared count of accepted bits. The input is a stream with a bit and a valid strobe but no ready. The block accepts a bit in every cycle where the strobe is high, so it never applies back-pressure. The output is a plain word with a one-cycle valid pulse, and it cannot be stalled: a consumer must take each word within the 64 accepted bits that follow it.

Top module: `serial_cascade_deser`

## Requirements
- R1: Within a word, the n-th accepted bit (counting from 0) lands at bit n of `word_data`. The first bit after reset or after a word boundary is at bit 0, and the last is at bit 63.
- R2: A word is produced after every 64 accepted bits. `word_data` and `word_valid` change at the clock edge that accepts the 64th bit. No word appears after 63 bits.
- R3: `word_valid` is high for exactly one cycle per word.
- R4: `word_data` holds its value between word loads.
- R5: In a cycle with `ser_valid` low, `ser_bit` is ignored and no state advances. Idle cycles inside a word leave the assembled word unchanged.
- R6: A synchronous reset clears `word_data` to zero and `word_valid` to 0.
- R7: With `ser_valid` held high, consecutive words follow with no lost bit, and their `word_valid` pulses are exactly 64 cycles apart.
- R8: A reset in the middle of a word discards the partial bits, so the next accepted bit becomes bit 0 of a new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every stage |
| rst | input | 1 | Synchronous reset, active high |
| ser_bit | input | 1 | Serial data bit |
| ser_valid | input | 1 | High when `ser_bit` carries a bit to accept |
| word_data | output | 64 | Assembled word; bit 0 is the earliest bit |
| word_valid | output | 1 | One-cycle pulse marking a new word |

## Verification
The hardest case to reach from the ports is an idle gap that falls exactly where several stages would hand a chunk onward. Such a gap must stall the whole cascade without dropping or repeating a chunk. The stimulus inserts idle runs at periodic and at random bit positions, and it toggles `ser_bit` while `ser_valid` is low. A long unbroken run checks that a handoff at a word boundary chains directly into the next word.

// File: rtl/s2p_cascade_pkg.sv
package s2p_cascade_pkg;
  localparam int unsigned S2P_WORD_W_DEF = 64;

  // width of cascade stage idx (stage 0 is the 2-bit front)
  function automatic int unsigned s2p_stage_w(input int unsigned idx);
    return 2 << idx;
  endfunction
endpackage

// File: rtl/s2p_bit_counter.sv
module s2p_bit_counter #(
  parameter int unsigned WORD_W = 64,
  localparam int unsigned CNT_W = $clog2(WORD_W),
  localparam int unsigned N_ST  = CNT_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  output logic [N_ST-1:0] stage_en,
  output logic            word_done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (accept) cnt_q <= cnt_q + 1'b1;
  end

  // stage i takes a chunk once the low i count bits are all ones
  for (genvar i = 0; i < N_ST; i++) begin : g_en
    if (i == 0) begin : g_front
      assign stage_en[i] = accept;
    end else begin : g_later
      assign stage_en[i] = accept && (&cnt_q[i-1:0]);
    end
  end

  assign word_done = accept && (&cnt_q);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(cnt_q)); // R5
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    word_done |=> (cnt_q == '0)); // R2
  AST_EN_NESTED: assert property (@(posedge clk) disable iff (rst)
    word_done |-> (&stage_en)); // R7
endmodule

// File: rtl/s2p_stage.sv
module s2p_stage #(
  parameter int unsigned W = 4,
  localparam int unsigned HALF = W / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [HALF-1:0] chunk_in,
  output logic [W-1:0]    chunk_out
);
  logic [W-1:0] hold_q;

  // newest chunk enters the upper half so the earliest bits end up low
  assign chunk_out = {chunk_in, hold_q[W-1:HALF]};

  always_ff @(posedge clk) begin
    if (rst)     hold_q <= '0;
    else if (en) hold_q <= chunk_out;
  end

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(hold_q)); // R5
endmodule

// File: rtl/s2p_word_capture.sv
module s2p_word_capture #(
  parameter int unsigned WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_q,
  output logic              valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) word_q <= word_in;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q); // R3
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(word_q)); // R4
  AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (valid_q && word_q == $past(word_in))); // R2
endmodule

// File: rtl/serial_cascade_deser.sv
module serial_cascade_deser
  import s2p_cascade_pkg::*;
#(
  parameter int unsigned WORD_W = S2P_WORD_W_DEF,
  localparam int unsigned N_ST = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_bit,
  input  logic              ser_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid
);
  logic [N_ST-1:0] stage_en;
  logic            word_done;

  s2p_bit_counter #(.WORD_W(WORD_W)) i_cnt (
    .clk       (clk),
    .rst       (rst),
    .accept    (ser_valid),
    .stage_en  (stage_en),
    .word_done (word_done)
  );

  for (genvar i = 0; i < N_ST; i++) begin : g_st
    localparam int unsigned SW = s2p_stage_w(i);
    logic [SW-1:0]   c;
    logic [SW/2-1:0] cin;
    if (i == 0) begin : g_src_bit
      assign cin = ser_bit;
    end else begin : g_src_prev
      assign cin = g_st[i-1].c;
    end
    s2p_stage #(.W(SW)) i_stage (
      .clk       (clk),
      .rst       (rst),
      .en        (stage_en[i]),
      .chunk_in  (cin),
      .chunk_out (c)
    );
  end

  s2p_word_capture #(.WORD_W(WORD_W)) i_cap (
    .clk     (clk),
    .rst     (rst),
    .load    (word_done),
    .word_in (g_st[N_ST-1].c),
    .word_q  (word_data),
    .valid_q (word_valid)
  );
endmodule

// File: tb/test_serial_cascade_deser.sv
`timescale 1ns/1ps
module test_serial_cascade_deser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_bit = 1'b0;
  logic        ser_valid = 1'b0;
  logic [63:0] word_data;
  logic        word_valid;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  serial_cascade_deser i_serial_cascade_deser (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .ser_valid(ser_valid),
    .word_data(word_data), .word_valid(word_valid)
  );

  // {gap length, word}; gap inserted after bits with k % 5 == 2
  localparam logic [71:0] VEC [6] = '{
    {8'd0, 64'h0000_0000_0000_0001},
    {8'd1, 64'h8000_0000_0000_0000},
    {8'd3, 64'hFFFF_FFFF_FFFF_FFFF},
    {8'd0, 64'hAAAA_5555_AAAA_5555},
    {8'd2, 64'h0123_4567_89AB_CDEF},
    {8'd5, 64'hF0F0_0F0F_C3C3_3C3C}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic b);
    ser_bit = b;
    ser_valid = 1'b1;
    @(posedge clk); #1;
    ser_valid = 1'b0;
    ser_bit = 1'($urandom);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      ser_bit = 1'($urandom);
      @(posedge clk); #1;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ser_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [63:0] ref_w;
    logic [63:0] held;
    logic        b;
    do_reset();
    chk("R6 reset data", word_data, 64'd0);
    chk("R6 reset valid", 64'(word_valid), 64'd0);

    // table walk: R1 order, R2 timing, R3 pulse, R4 hold, R5 gaps
    for (int v = 0; v < 6; v++) begin
      for (int k = 0; k < 64; k++) begin
        push(VEC[v][k]);
        if (k == 62) chk("R2 no word after 63 bits", 64'(word_valid), 64'd0);
        if (VEC[v][71:64] != 0 && (k % 5) == 2 && k != 63) idle(int'(VEC[v][71:64]));
      end
      chk("R2 valid at 64th bit", 64'(word_valid), 64'd1);
      chk("R1 word order", word_data, VEC[v][63:0]);
      idle(1);
      chk("R3 valid one cycle", 64'(word_valid), 64'd0);
      chk("R4 word held", word_data, VEC[v][63:0]);
    end

    // R7: unbroken stream of two words
    ref_w = '0;
    for (int k = 0; k < 128; k++) begin
      b = 1'($urandom);
      ref_w = {b, ref_w[63:1]};
      push(b);
      if (k == 63 || k == 127) begin
        chk("R7 valid on word boundary", 64'(word_valid), 64'd1);
        chk("R7 contiguous word", word_data, ref_w);
      end
      if (k == 64) chk("R7 valid drops", 64'(word_valid), 64'd0);
      if (k == 126) chk("R7 no early valid", 64'(word_valid), 64'd0);
    end

    // R5: random gaps with toggling ser_bit during idle
    for (int w = 0; w < 4; w++) begin
      held = word_data;
      for (int k = 0; k < 64; k++) begin
        b = 1'($urandom);
        ref_w = {b, ref_w[63:1]};
        push(b);
        if (k < 63 && ($urandom % 3) == 0) begin
          idle(1 + int'($urandom % 4));
          if (k == 62) begin
            chk("R5 no word during idle", 64'(word_valid), 64'd0);
            chk("R5 word unchanged during idle", word_data, held);
          end
        end
      end
      chk("R5 valid after gapped word", 64'(word_valid), 64'd1);
      chk("R5 gapped word matches", word_data, ref_w);
      idle(2);
    end

    // R8: reset mid-word discards partial bits
    for (int k = 0; k < 20; k++) push(1'b1);
    do_reset();
    chk("R6 reset clears data", word_data, 64'd0);
    chk("R6 reset clears valid", 64'(word_valid), 64'd0);
    for (int k = 0; k < 64; k++) push(VEC[4][k]);
    chk("R8 fresh word after reset", word_data, VEC[4][63:0]);
    chk("R8 valid after reset word", 64'(word_valid), 64'd1);

    summary();
  end
endmodule